// File: doc/BRIEF.md
# Toggle-Request Word Memory with Byte-Address Controller

This block is a single-port store of 32-bit words. It is driven by a small finite-state-machine controller that runs on the rising clock edge. The controller takes one command at a time: a byte address, a write flag and, for a write, a data word. It turns the byte address into a word index by subtracting a base offset and dividing by four. It then posts the access to the memory by inverting a request bit. The memory runs on the falling edge. It acts only when that request bit differs from an acknowledge bit it keeps. It performs exactly one write or read for each inversion, then copies the request into the acknowledge bit and goes quiet again.

A store posts and completes inside one controller cycle, so the controller can accept the next command straight away. A load needs a second controller state. The word captured on the falling edge is copied into the response register in that extra state, and the response is presented from the following cycle. Commands whose byte address is not a multiple of four, lies below the base, or points past the last word are refused with an error pulse and never reach the array.

Top module: `tglram_sys`

## Requirements
- R1: After reset the request and acknowledge bits are both 0, so no access is pending. `cmd_ready` is 1, `cmd_err` and `rsp_valid` are 0, and `rsp_data` is 0.
- R2: A valid write accepted on a rising edge stores `cmd_wdata` on the next falling edge. `cmd_ready` remains 1, so a new command can be taken on the very next rising edge.
- R3: A valid read accepted on rising edge k drops `cmd_ready` to 0 for one cycle. On edge k+1, `rsp_valid` rises for exactly one cycle and `rsp_data` holds the stored word. `cmd_ready` returns to 1 on that same edge.
- R4: The word index is (byte address − BASE) / 4. Each aligned byte address in [BASE, BASE + 4·DEPTH) reaches its own word, including the first and the last.
- R5: A command whose byte address has bits [1:0] ≠ 0, is below BASE, or is at or beyond BASE + 4·DEPTH makes no memory access. `cmd_err` is 1 for the one cycle after acceptance, no response is produced, and the request bit does not change.
- R6: The memory acts only while the request bit differs from its acknowledge bit. Each inversion is served on the next falling edge, and by every rising edge the two bits agree again.
- R7: While no load completes, `rsp_data` keeps its last value, and the memory's internal read-data register keeps its value during writes and idle falling edges.
- R8: Commands accepted on consecutive rising edges are each served exactly once and in order. A read issued on the cycle right after a write to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controller on rising edge, memory on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | BA_W | Byte address of the command |
| cmd_wdata | input | 32 | Store data |
| cmd_ready | output | 1 | Controller can take a command this cycle |
| cmd_err | output | 1 | One-cycle pulse: last accepted command was refused |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` carries a load result |
| rsp_data | output | 32 | Load result register |

## Verification
A store is accepted on one rising edge, and on the same edge's settled outputs `cmd_ready` is already 1 again. A load shows `cmd_ready` at 0 after its acceptance edge and its `rsp_valid` and data one rising edge later. A refused command shows `cmd_err` after the acceptance edge. The bench drives inputs and samples outputs 1 ns after each rising edge, so every check lands in exactly the cycle those latencies name. Expected words come from a bench-side array indexed by its own byte-to-word function. Words never written are not compared. Burst writes followed at once by a read of the same word exercise the falling-edge service of back-to-back inversions.

// File: rtl/tglram_pkg.sv
`timescale 1ns/1ps
package tglram_pkg;
   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic {ST_IDLE = 1'b0, ST_LOAD = 1'b1} ctrl_st_e;
endpackage

// File: rtl/tglram_addr_map.sv
`timescale 1ns/1ps
// Byte address to word index, with alignment and range qualification.
module tglram_addr_map #(
   parameter int unsigned BA_W  = 16,
   parameter int unsigned BASE  = 256,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic [BA_W-1:0]  byte_addr_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             ok_o
);
   localparam int unsigned       WA_W   = BA_W - 2;
   localparam logic [BA_W-1:0]   BASE_V = BA_W'(BASE);

   logic [BA_W-1:0] rel;
   logic            below;
   logic [WA_W-1:0] wrd;
   logic            aligned;
   logic            in_range;

   generate
      if (BASE == 0) begin : g_no_base
         assign rel   = byte_addr_i;
         assign below = 1'b0;
      end else begin : g_base
         assign rel   = byte_addr_i - BASE_V;
         assign below = (byte_addr_i < BASE_V);
      end
   endgenerate

   assign aligned  = (rel[1:0] == 2'b00);
   assign wrd      = rel[BA_W-1:2];
   assign in_range = (32'(wrd) < 32'(DEPTH));
   assign idx_o    = wrd[IDX_W-1:0];
   assign ok_o     = aligned && in_range && !below;
endmodule

// File: rtl/tglram_mem.sv
`timescale 1ns/1ps
// Falling-edge word array; served once per inversion of the request bit.
module tglram_mem
   import tglram_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             we_i,
   input  logic [IDX_W-1:0] idx_i,
   input  word_t            wdata_i,
   output word_t            rd_o,
   output logic             ack_o
);
   word_t arr [DEPTH];
   word_t rd_q;
   logic  ack_q;

   // Array only touched here so that a RAM is inferred.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         rd_q  <= '0;
      end else if (req_i != ack_q) begin
         if (we_i) arr[idx_i] <= wdata_i;
         else      rd_q       <= arr[idx_i];
         ack_q <= req_i;
      end
   end

   assign rd_o  = rd_q;
   assign ack_o = ack_q;

   // R7: read register untouched on idle edges and on writes
   a_r7_rd_hold: assert property (@(negedge clk) disable iff (!rst_n)
      ((req_i == ack_q) || we_i) |=> $stable(rd_q));
endmodule

// File: rtl/tglram_ctrl.sv
`timescale 1ns/1ps
// Rising-edge command controller posting toggle requests to the memory.
module tglram_ctrl
   import tglram_pkg::*;
#(
   parameter int unsigned BA_W  = 16,
   parameter int unsigned BASE  = 256,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid_i,
   input  logic             cmd_write_i,
   input  logic [BA_W-1:0]  cmd_addr_i,
   input  word_t            cmd_wdata_i,
   output logic             cmd_ready_o,
   output logic             cmd_err_o,
   output logic             rsp_valid_o,
   output word_t            rsp_data_o,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [IDX_W-1:0] mem_idx_o,
   output word_t            mem_wdata_o,
   input  word_t            mem_rd_i
);
   ctrl_st_e         st_q;
   logic [IDX_W-1:0] idx;
   logic             ok;
   logic             take;

   tglram_addr_map #(.BA_W(BA_W), .BASE(BASE), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_map (
      .byte_addr_i (cmd_addr_i),
      .idx_o       (idx),
      .ok_o        (ok)
   );

   assign cmd_ready_o = (st_q == ST_IDLE);
   assign take        = cmd_valid_i && cmd_ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         mem_req_o   <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_idx_o   <= '0;
         mem_wdata_o <= '0;
         cmd_err_o   <= 1'b0;
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         cmd_err_o   <= 1'b0;
         rsp_valid_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (take) begin
                  if (ok) begin
                     mem_idx_o <= idx;
                     mem_we_o  <= cmd_write_i;
                     if (cmd_write_i) mem_wdata_o <= cmd_wdata_i;
                     mem_req_o <= ~mem_req_o;
                     if (!cmd_write_i) st_q <= ST_LOAD;
                  end else begin
                     cmd_err_o <= 1'b1;
                  end
               end
            end
            ST_LOAD: begin
               rsp_data_o  <= mem_rd_i;
               rsp_valid_o <= 1'b1;
               st_q        <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R2: a store posts its inversion and leaves the controller ready
   a_r2_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ok && cmd_write_i) |=> (cmd_ready_o && (mem_req_o != $past(mem_req_o))));
   // R3: load capture state is followed by the response pulse
   a_r3_load_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOAD) |=> (rsp_valid_o && cmd_ready_o));
   // R5: refused command flags an error and posts nothing
   a_r5_bad_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !ok) |=> (cmd_err_o && $stable(mem_req_o) && !rsp_valid_o));
   // R7: response register moves only when a load completes
   a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_LOAD) |=> $stable(rsp_data_o));
endmodule

// File: rtl/tglram_sys.sv
`timescale 1ns/1ps
module tglram_sys
   import tglram_pkg::*;
#(
   parameter int unsigned BA_W  = 16,
   parameter int unsigned BASE  = 256,
   parameter int unsigned DEPTH = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic            cmd_write,
   input  logic [BA_W-1:0] cmd_addr,
   input  logic [31:0]     cmd_wdata,
   output logic            cmd_ready,
   output logic            cmd_err,
   output logic            rsp_valid,
   output logic [31:0]     rsp_data
);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_chk_depth
         $error("tglram_sys: DEPTH must be at least 2");
      end
      if (BASE % 4 != 0) begin : g_chk_base
         $error("tglram_sys: BASE must be word aligned");
      end
      if (BA_W > 32 || BA_W < 3) begin : g_chk_baw
         $error("tglram_sys: BA_W must lie in 3..32");
      end
      if (IDX_W > BA_W - 2) begin : g_chk_idx
         $error("tglram_sys: BA_W too narrow for DEPTH");
      end
      if (64'(BASE) + 64'(4) * 64'(DEPTH) > (64'(1) << BA_W)) begin : g_chk_span
         $error("tglram_sys: window exceeds byte address space");
      end
   endgenerate

   logic             req;
   logic             ack;
   logic             we;
   logic [IDX_W-1:0] idx;
   word_t            wdata;
   word_t            rd;

   tglram_ctrl #(.BA_W(BA_W), .BASE(BASE), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_write_i (cmd_write),
      .cmd_addr_i  (cmd_addr),
      .cmd_wdata_i (cmd_wdata),
      .cmd_ready_o (cmd_ready),
      .cmd_err_o   (cmd_err),
      .rsp_valid_o (rsp_valid),
      .rsp_data_o  (rsp_data),
      .mem_req_o   (req),
      .mem_we_o    (we),
      .mem_idx_o   (idx),
      .mem_wdata_o (wdata),
      .mem_rd_i    (rd)
   );

   tglram_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .we_i    (we),
      .idx_i   (idx),
      .wdata_i (wdata),
      .rd_o    (rd),
      .ack_o   (ack)
   );

   // R6: every inversion is served by the falling edge before the next rising edge
   a_r6_ack_caught_up: assert property (@(posedge clk) disable iff (!rst_n)
      req == ack);
   // R1: nothing pending straight out of reset
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!req && !ack));
endmodule

// File: tb/tglram_sys_tb.sv
`timescale 1ns/1ps
module tglram_sys_tb_top;
   localparam int unsigned BA_W  = 16;
   localparam int unsigned BASE  = 256;
   localparam int unsigned DEPTH = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0;
   logic            cmd_write = 1'b0;
   logic [BA_W-1:0] cmd_addr = '0;
   logic [31:0]     cmd_wdata = '0;
   logic            cmd_ready;
   logic            cmd_err;
   logic            rsp_valid;
   logic [31:0]     rsp_data;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] mdl [DEPTH];
   bit          mv  [DEPTH];

   always #2.5 clk = ~clk;

   tglram_sys #(.BA_W(BA_W), .BASE(BASE), .DEPTH(DEPTH)) dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_write (cmd_write),
      .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata), .cmd_ready (cmd_ready),
      .cmd_err (cmd_err), .rsp_valid (rsp_valid), .rsp_data (rsp_data)
   );

   function automatic bit f_ok(input logic [BA_W-1:0] a);
      return (a[1:0] == 2'b00) && (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE + 4*DEPTH));
   endfunction

   function automatic int f_idx(input logic [BA_W-1:0] a);
      return (int'(a) - int'(BASE)) / 4;
   endfunction

   task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One command; checks land 1 ns after the acceptance edge and, for loads, the edge after.
   task automatic do_op(input bit wr, input logic [BA_W-1:0] a, input logic [31:0] d);
      bit ok;
      int i;
      ok = f_ok(a);
      i  = ok ? f_idx(a) : 0;
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      if (!ok) begin
         chk(cmd_err == 1'b1 && cmd_ready == 1'b1, "R5 refused err", {30'd0, cmd_err, cmd_ready}, 32'd3);
         @(posedge clk); #1;
         chk(rsp_valid == 1'b0 && cmd_err == 1'b0, "R5 no response", {30'd0, rsp_valid, cmd_err}, 32'd0);
      end else if (wr) begin
         chk(cmd_ready == 1'b1 && cmd_err == 1'b0, "R2 store ready", {30'd0, cmd_ready, cmd_err}, 32'd2);
         mdl[i] = d;
         mv[i]  = 1'b1;
      end else begin
         chk(cmd_ready == 1'b0 && rsp_valid == 1'b0, "R3 load stall", {30'd0, cmd_ready, rsp_valid}, 32'd0);
         @(posedge clk); #1;
         chk(rsp_valid == 1'b1 && cmd_ready == 1'b1, "R3 load resp", {30'd0, rsp_valid, cmd_ready}, 32'd3);
         if (mv[i]) chk(rsp_data == mdl[i], "R4 load data", rsp_data, mdl[i]);
      end
   endtask

   // R8: writes on consecutive edges, then a read of the last word on the very next edge
   task automatic burst(input int first, input int n, input logic [31:0] seed_d);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_write = 1'b1;
      for (int k = 0; k < n; k++) begin
         cmd_addr  = BA_W'(BASE + 4 * (first + k));
         cmd_wdata = seed_d ^ (32'(k) * 32'h0101_0101);
         @(posedge clk); #1;
         chk(cmd_ready == 1'b1, "R8 burst ready", {31'd0, cmd_ready}, 32'd1);
         mdl[first + k] = seed_d ^ (32'(k) * 32'h0101_0101);
         mv[first + k]  = 1'b1;
      end
      cmd_write = 1'b0;
      cmd_addr  = BA_W'(BASE + 4 * (first + n - 1));
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      @(posedge clk); #1;
      chk(rsp_valid == 1'b1 && rsp_data == mdl[first + n - 1], "R8 read after write",
          rsp_data, mdl[first + n - 1]);
      for (int k = 0; k < n; k++) do_op(1'b0, BA_W'(BASE + 4 * (first + k)), 32'd0);
   endtask

   initial begin : main
      logic [31:0] held;
      void'($urandom(32'd20240611));
      for (int k = 0; k < DEPTH; k++) mv[k] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk(cmd_ready == 1'b1 && cmd_err == 1'b0 && rsp_valid == 1'b0, "R1 reset outputs",
          {29'd0, cmd_ready, cmd_err, rsp_valid}, 32'd4);
      chk(rsp_data == 32'd0, "R1 reset data", rsp_data, 32'd0);

      // R4 boundaries: first and last word
      do_op(1'b1, BA_W'(BASE), 32'hA5A5_0001);
      do_op(1'b1, BA_W'(BASE + 4 * (DEPTH - 1)), 32'h5A5A_FFFE);
      do_op(1'b1, BA_W'(BASE + 4), 32'h1111_2222);
      do_op(1'b0, BA_W'(BASE), 32'd0);
      do_op(1'b0, BA_W'(BASE + 4 * (DEPTH - 1)), 32'd0);
      do_op(1'b0, BA_W'(BASE + 4), 32'd0);

      // R5: misaligned, below base and past end leave memory untouched
      do_op(1'b1, BA_W'(BASE + 2), 32'hDEAD_BEEF);
      do_op(1'b1, BA_W'(BASE + 5), 32'hDEAD_BEEF);
      do_op(1'b1, BA_W'(BASE - 4), 32'hDEAD_BEEF);
      do_op(1'b1, BA_W'(BASE + 4 * DEPTH), 32'hDEAD_BEEF);
      do_op(1'b0, BA_W'(BASE + 4 * DEPTH + 8), 32'd0);
      do_op(1'b0, BA_W'(BASE), 32'd0);
      do_op(1'b0, BA_W'(BASE + 4), 32'd0);

      // R7: response register holds across writes and refused commands
      held = rsp_data;
      do_op(1'b1, BA_W'(BASE + 40), 32'h7777_0000);
      do_op(1'b1, BA_W'(BASE + 3), 32'h0);
      chk(rsp_data == held, "R7 rsp hold", rsp_data, held);

      // R8 / R6: back-to-back inversions
      burst(8, 5, 32'hC0DE_0000);
      burst(DEPTH - 3, 3, 32'h0BAD_F00D);

      // Random mix
      for (int n = 0; n < 400; n++) begin
         int r;
         logic [BA_W-1:0] a;
         r = $urandom_range(0, 9);
         if (r == 0)      a = BA_W'(BASE + 4 * $urandom_range(0, DEPTH - 1) + $urandom_range(1, 3));
         else if (r == 1) a = BA_W'(BASE + 4 * DEPTH + 4 * $urandom_range(0, 20));
         else if (r == 2) a = BA_W'(4 * $urandom_range(0, BASE / 4 - 1));
         else             a = BA_W'(BASE + 4 * $urandom_range(0, DEPTH - 1));
         if ($urandom_range(0, 2) == 0) begin
            held = rsp_data;
            do_op(1'b1, a, $urandom());
            chk(rsp_data == held, "R7 rsp hold rand", rsp_data, held);
         end else begin
            do_op($urandom_range(0, 1) == 1, a, $urandom());
         end
      end

      // Final sweep reads every word written so far
      for (int k = 0; k < DEPTH; k++)
         if (mv[k]) do_op(1'b0, BA_W'(BASE + 4 * k), 32'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule